// File: doc/BRIEF.md
# Microcoded Scan Command Sequencer

This block is the control path of a scan test engine. It replaces a hard-coded state machine with a writable control store. Each Moore state of a command is one microcode word. Every word carries three things: a jump target, a flow operation, and a set of control bits. The control bits go straight to the datapath strobes and to the test clock and mode pins. The sequencer executes one word per clock. The outputs come only from the word at the current address.

Two words at the bottom of the store are shared by every command.
- Word 0 is shown while the sequencer waits for an opcode.
- Word 1 is shown for the single dispatch cycle.

A small writable table gives the first address of each opcode's program. Targets inside a program are offsets from that first address. A program therefore occupies exactly as many words as it has states, and programs can be packed one after another. The reserved offset (all ones) means "end of command" and returns control to word 0.

The sequencer has three named states:
- `SQ_IDLE`: waits at address 0. Its transition *accept* fires when a command is valid and the sequencer is not held.
- `SQ_DISPATCH`: one cycle at address 1. Its transition *enter* always goes to the run state, at offset 0 of the selected program.
- `SQ_RUN`: executes the program. Its transitions are *step* (offset plus one), *transfer* (offset takes the target) and *finish* (a taken transfer to the end offset, back to idle).

The store and the base table can be written only while the sequencer is idle and held.

Top module: `useq_top`

## Requirements
- R1: After reset the sequencer is in `SQ_IDLE` with `upc_o` = 0 and `busy_o` = 0, and every store word and base entry is zero, so `ctrl_o` reads 0.
- R2: `cmd_ready_o` is 1 exactly when the sequencer is idle and `hold_i` is 0. A command presented while held is not taken, and `busy_o` stays 0.
- R3: On the clock edge that accepts a command, the sequencer moves to `SQ_DISPATCH` and spends one cycle with `upc_o` = 1. On the next edge it enters `SQ_RUN` with `upc_o` equal to the base entry of the accepted opcode.
- R4: A word whose flow field is CONTINUE (bit 0), or is all zero, or is a branch that is not taken, moves to the next offset.
- R5: A word with JUMP (flow bit 1) moves to its target offset.
- R6: Flow bit 2+2k branches to the target when condition `cond_i[k]` is 1. Flow bit 3+2k branches to the target when `cond_i[k]` is 0. Otherwise the sequencer continues to the next offset.
- R7: A taken jump or branch whose target offset is all ones ends the command. On the next cycle `upc_o` = 0 and `busy_o` = 0.
- R8: `ctrl_o` always equals the control field of the word at `upc_o`, including words 0 and 1 while idle and dispatching.
- R9: Writes to the store and the base table take effect only while idle with `hold_i` = 1. At any other time they are ignored.
- R10: A word is laid out as {target offset [OFFW], flow field [2+2*NCOND], control bits [NCTRL]}, with the control bits in the least significant positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_i | input | 1 | Keeps the sequencer idle and opens the write port |
| cmd_valid_i | input | 1 | A command opcode is offered |
| cmd_op_i | input | OPW | Command opcode |
| cmd_ready_o | output | 1 | Opcode is taken this cycle if valid |
| cond_i | input | NCOND | Datapath condition flags |
| uw_we_i | input | 1 | Store word write enable |
| uw_addr_i | input | AW | Store word address |
| uw_data_i | input | OFFW+2+2*NCOND+NCTRL | Store word data |
| bt_we_i | input | 1 | Base table write enable |
| bt_op_i | input | OPW | Base table entry (opcode) |
| bt_base_i | input | AW | First address of that opcode's program |
| ctrl_o | output | NCTRL | Control field of the current word |
| upc_o | output | AW | Current microcode address |
| busy_o | output | 1 | A command is being dispatched or run |

## Verification
The bench runs a clock-pulse loop program against a bench model of a down counter, with counts of zero, one and five:
- A sequencer with an inverted branch sense would emit the wrong number of clock pulses.
- A sequencer that treats a branch as a jump would loop forever or stop after one pass.
- A sequencer that resolved offsets absolutely instead of from the base would fetch the shared words and stall in idle.

It exercises a true-sense branch both ways and a zero flow field that must fall through. It also checks that the end offset lands back at address 0 in one cycle.

The write port is tried in two illegal conditions: during a run, and while idle but not held. The stray store and base writes would redirect a later command, so a sequencer that took them produces the wrong control bits or the wrong start address on that later command.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_DISPATCH = 2'd1,
        SQ_RUN      = 2'd2
    } sq_state_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW  = 6,
    parameter int OPW = 3,
    parameter int WW  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_allow,
    input  logic          uw_we,
    input  logic [AW-1:0] uw_addr,
    input  logic [WW-1:0] uw_data,
    input  logic          bt_we,
    input  logic [OPW-1:0] bt_op,
    input  logic [AW-1:0] bt_base,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] rd_word,
    input  logic [OPW-1:0] op_sel,
    output logic [AW-1:0] base_rd
);
    localparam int DEPTH = 1 << AW;
    localparam int NOP   = 1 << OPW;

    logic [WW-1:0]           mem_q [DEPTH];
    logic [NOP-1:0][AW-1:0]  bt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            bt_q <= '0;
        end else if (wr_allow) begin
            if (uw_we) mem_q[uw_addr] <= uw_data;
            if (bt_we) bt_q[bt_op]    <= bt_base;
        end
    end

    assign rd_word = mem_q[rd_addr];
    assign base_rd = bt_q[op_sel];

    AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(bt_q)); // R9
endmodule

// File: rtl/useq_next.sv
module useq_next #(
    parameter int OFFW  = 4,
    parameter int NCOND = 2
) (
    input  logic [2+2*NCOND-1:0] uop,
    input  logic [NCOND-1:0]     cond,
    input  logic [OFFW-1:0]      tgt,
    input  logic [OFFW-1:0]      off,
    output logic                 take,
    output logic                 is_end,
    output logic [OFFW-1:0]      off_nxt
);
    logic [NCOND-1:0] hit;

    for (genvar k = 0; k < NCOND; k++) begin : g_br
        assign hit[k] = (uop[2+2*k] & cond[k]) | (uop[3+2*k] & ~cond[k]);
    end

    always_comb begin
        take    = uop[1] | (|hit);
        is_end  = (tgt == {OFFW{1'b1}});
        off_nxt = take ? tgt : off + 1'b1;
    end
endmodule

// File: rtl/useq_top.sv
module useq_top #(
    parameter int AW    = 6,
    parameter int OPW   = 3,
    parameter int OFFW  = 4,
    parameter int NCOND = 2,
    parameter int NCTRL = 10,
    parameter int UOPW  = 2 + 2*NCOND,
    parameter int WW    = OFFW + UOPW + NCTRL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             cmd_valid_i,
    input  logic [OPW-1:0]   cmd_op_i,
    output logic             cmd_ready_o,
    input  logic [NCOND-1:0] cond_i,
    input  logic             uw_we_i,
    input  logic [AW-1:0]    uw_addr_i,
    input  logic [WW-1:0]    uw_data_i,
    input  logic             bt_we_i,
    input  logic [OPW-1:0]   bt_op_i,
    input  logic [AW-1:0]    bt_base_i,
    output logic [NCTRL-1:0] ctrl_o,
    output logic [AW-1:0]    upc_o,
    output logic             busy_o
);
    import useq_pkg::*;

    sq_state_e       state_q, state_d;
    logic [OPW-1:0]  op_q, op_d;
    logic [AW-1:0]   base_q, base_d;
    logic [OFFW-1:0] off_q, off_d;

    logic [WW-1:0]   word;
    logic [AW-1:0]   base_rd;
    logic [UOPW-1:0] uop_w;
    logic [OFFW-1:0] tgt_w;
    logic            take, is_end, wr_allow;
    logic [OFFW-1:0] off_nxt;

    assign uop_w = word[NCTRL +: UOPW];
    assign tgt_w = word[WW-1 -: OFFW];

    useq_store #(.AW(AW), .OPW(OPW), .WW(WW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow),
        .uw_we(uw_we_i), .uw_addr(uw_addr_i), .uw_data(uw_data_i),
        .bt_we(bt_we_i), .bt_op(bt_op_i), .bt_base(bt_base_i),
        .rd_addr(upc_o), .rd_word(word),
        .op_sel(op_q), .base_rd(base_rd)
    );

    useq_next #(.OFFW(OFFW), .NCOND(NCOND)) u_next (
        .uop(uop_w), .cond(cond_i), .tgt(tgt_w), .off(off_q),
        .take(take), .is_end(is_end), .off_nxt(off_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        base_d  = base_q;
        off_d   = off_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (cmd_valid_i && !hold_i) begin      // accept
                    state_d = SQ_DISPATCH;
                    op_d    = cmd_op_i;
                end
            end
            SQ_DISPATCH: begin                         // enter
                state_d = SQ_RUN;
                base_d  = base_rd;
                off_d   = '0;
            end
            SQ_RUN: begin
                if (take && is_end) state_d = SQ_IDLE; // finish
                else                off_d   = off_nxt; // step / transfer
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            op_q    <= '0;
            base_q  <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            base_q  <= base_d;
            off_q   <= off_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SQ_IDLE:     upc_o = '0;
            SQ_DISPATCH: upc_o = AW'(1);
            SQ_RUN:      upc_o = base_q + AW'(off_q);
            default:     upc_o = '0;
        endcase
        busy_o      = (state_q != SQ_IDLE);
        cmd_ready_o = (state_q == SQ_IDLE) && !hold_i;
        wr_allow    = (state_q == SQ_IDLE) && hold_i;
        ctrl_o      = word[NCTRL-1:0];
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !busy_o && !hold_i); // R2
    AST_ACCEPT_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i && cmd_ready_o |=> busy_o && upc_o == AW'(1)); // R3
    AST_ENTER_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SQ_DISPATCH |=> upc_o == $past(base_rd)); // R3
    AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SQ_RUN && uop_w[0] && !take && off_q != {OFFW{1'b1}}
        |=> upc_o == $past(upc_o) + 1'b1); // R4
    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SQ_RUN && take && is_end |=> upc_o == '0 && !busy_o); // R7
endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6, OPW = 3, OFFW = 4, NCOND = 2, NCTRL = 10;
    localparam int WW = OFFW + 2 + 2*NCOND + NCTRL;
    localparam logic [5:0] U_CONT = 6'b000001, U_JMP = 6'b000010,
                           U_BT1  = 6'b010000, U_BF0 = 6'b001000;
    localparam logic [3:0] T_END = 4'hF;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] n;
        logic       c1;
        logic       intr;
        logic [7:0] cyc;
        logic [7:0] tck;
        logic [9:0] last;
        logic [5:0] base;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd1, 8'd0, 1'b0, 1'b0, 8'd3,  8'd1, 10'h001, 6'd2},
        '{3'd1, 8'd1, 1'b0, 1'b0, 8'd5,  8'd2, 10'h001, 6'd2},
        '{3'd1, 8'd5, 1'b0, 1'b1, 8'd13, 8'd6, 10'h001, 6'd2},
        '{3'd2, 8'd0, 1'b0, 1'b0, 8'd1,  8'd1, 10'h003, 6'd6},
        '{3'd3, 8'd0, 1'b1, 1'b0, 8'd2,  8'd0, 10'h080, 6'd7},
        '{3'd3, 8'd0, 1'b0, 1'b0, 8'd2,  8'd0, 10'h040, 6'd7},
        '{3'd4, 8'd0, 1'b0, 1'b0, 8'd3,  8'd0, 10'h006, 6'd10},
        '{3'd2, 8'd0, 1'b0, 1'b0, 8'd1,  8'd1, 10'h003, 6'd6}
    };

    logic clk = 0, rst_n = 0, hold_i = 0, cmd_valid_i = 0;
    logic [OPW-1:0] cmd_op_i = '0;
    logic [NCOND-1:0] cond_i = '0;
    logic uw_we_i = 0, bt_we_i = 0;
    logic [AW-1:0] uw_addr_i = '0, bt_base_i = '0;
    logic [WW-1:0] uw_data_i = '0;
    logic [OPW-1:0] bt_op_i = '0;
    logic cmd_ready_o, busy_o;
    logic [NCTRL-1:0] ctrl_o;
    logic [AW-1:0] upc_o;

    int n_chk = 0, n_bad = 0;

    useq_top u_dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_ready_o(cmd_ready_o),
        .cond_i(cond_i), .uw_we_i(uw_we_i), .uw_addr_i(uw_addr_i), .uw_data_i(uw_data_i),
        .bt_we_i(bt_we_i), .bt_op_i(bt_op_i), .bt_base_i(bt_base_i),
        .ctrl_o(ctrl_o), .upc_o(upc_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WW-1:0] mk(input logic [3:0] t, input logic [5:0] u,
                                          input logic [9:0] c);
        return {t, u, c};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(input int a, input logic [WW-1:0] d);
        uw_we_i = 1; uw_addr_i = AW'(a); uw_data_i = d;
        @(negedge clk); uw_we_i = 0;
    endtask

    task automatic wr_base(input int op, input int b);
        bt_we_i = 1; bt_op_i = OPW'(op); bt_base_i = AW'(b);
        @(negedge clk); bt_we_i = 0;
    endtask

    task automatic run_cmd(input vec_t v, input int idx);
        int cyc = 0, tck = 0, cnt = 0;
        logic [9:0] last = '0;
        cmd_valid_i = 1; cmd_op_i = v.op;
        @(negedge clk);
        cmd_valid_i = 0;
        check($sformatf("R3 dispatch addr v%0d", idx), upc_o, 1);
        check($sformatf("R8 dispatch ctrl v%0d", idx), ctrl_o, 10'h100);
        @(negedge clk);
        check($sformatf("R3 run base v%0d", idx), upc_o, v.base);
        while (busy_o && cyc < 200) begin
            if (v.intr && cyc == 0) begin
                uw_we_i = 1; uw_addr_i = 6; uw_data_i = mk(T_END, U_JMP, 10'h3FF);
                bt_we_i = 1; bt_op_i = 3'd2; bt_base_i = 6'd0;
            end else begin
                uw_we_i = 0; bt_we_i = 0;
            end
            cond_i[0] = (cnt == 0);
            cond_i[1] = v.c1;
            cyc++;
            if (ctrl_o[0]) tck++;
            last = ctrl_o;
            if (ctrl_o[4])      cnt = v.n;
            else if (ctrl_o[3]) cnt = cnt - 1;
            @(negedge clk);
        end
        uw_we_i = 0; bt_we_i = 0;
        check($sformatf("R4 R5 R6 cycles v%0d", idx), cyc, v.cyc);
        check($sformatf("R6 tck pulses v%0d", idx), tck, v.tck);
        check($sformatf("R8 last ctrl v%0d", idx), last, v.last);
        check($sformatf("R7 back to idle v%0d", idx), upc_o, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset upc", upc_o, 0);
        check("R1 reset busy", busy_o, 0);
        check("R1 reset ctrl", ctrl_o, 0);
        check("R2 ready idle", cmd_ready_o, 1);

        hold_i = 1;
        @(negedge clk);
        check("R2 ready while held", cmd_ready_o, 0);
        cmd_valid_i = 1; cmd_op_i = 3'd2;
        repeat (3) @(negedge clk);
        check("R2 held command not taken", busy_o, 0);
        cmd_valid_i = 0;

        // load the programs while held (R10 layout)
        wr_word(0, mk(4'd0, U_CONT, 10'h200));
        wr_word(1, mk(4'd0, U_CONT, 10'h100));
        wr_word(2, mk(4'd0, U_CONT, 10'h010));
        wr_word(3, mk(4'd3, U_BF0, 10'h000));
        wr_word(4, mk(T_END, U_JMP, 10'h001));
        wr_word(5, mk(4'd1, U_JMP, 10'h009));
        wr_word(6, mk(T_END, U_JMP, 10'h003));
        wr_word(7, mk(4'd2, U_BT1, 10'h020));
        wr_word(8, mk(T_END, U_JMP, 10'h040));
        wr_word(9, mk(T_END, U_JMP, 10'h080));
        wr_word(10, mk(4'd0, 6'b0, 10'h004));
        wr_word(11, mk(4'd0, U_CONT, 10'h002));
        wr_word(12, mk(T_END, U_JMP, 10'h006));
        wr_base(1, 2); wr_base(2, 6); wr_base(3, 7); wr_base(4, 10);
        check("R9 R8 idle shows written word 0", ctrl_o, 10'h200);
        hold_i = 0;

        // write while idle but not held: ignored (R9)
        wr_word(0, mk(4'd0, U_CONT, 10'h155));
        wr_base(4, 0);
        check("R9 unheld write ignored", ctrl_o, 10'h200);

        for (int i = 0; i < 8; i++) run_cmd(VEC[i], i);

        check("R9 run-time write ignored, idle ctrl", ctrl_o, 10'h200);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule